// File: doc/BRIEF.md
# Multichannel DMA Channel Register File

This block holds the per-channel control and status registers of an eight-channel DMA controller. A processor reads and writes them over a simple strobe interface. Each channel owns a 32-byte window. Its word offsets select the transfer setup register, the control/status register, the address register and the count register. The block drives each channel's run, direction, width and timing outputs towards a separate transfer engine. That engine pulses one beat strobe per completed unit.

Each channel's run bit is a two-state machine. `CH_IDLE` goes to `CH_RUN` when software writes the run bit as 1. `CH_RUN` goes back to `CH_IDLE` on either of two transitions:

- the terminal beat, which is the beat that brings the count to zero;
- a software write with the run bit at 0.

While the channel is running, each beat advances the address by the transfer width and decrements the count. Memory and address error inputs set sticky flags. Software clears a flag by writing 1 to its position in the control/status register. A single interrupt line gathers the flags of all channels whose interrupt enable is set.

Top module: `dmarf_regbank`

## Requirements
- R1: After reset, every register reads 0, every channel output is 0 and `irq` is 0.
- R2: `cpu_addr[7:5]` selects the channel, which gives a 32-byte stride. `cpu_addr[4:2]` selects the register: 0 setup, 1 control/status, 2 address, 3 count. Selects 4 to 7 read as 0, and writes to them change nothing.
- R3: In the setup register, bit 0 is interrupt enable, bit 1 selects 16-bit width (`ch_wide`) and bit 2 selects the 120 ns access time (`ch_slow`, 0 means 80 ns). The register reads back as written.
- R4: In the control/status register, bit 0 is the run bit (`ch_enable`) and bit 1 is the direction bit (`ch_dir_wr`, 1 = memory write, 0 = memory read). Both appear on the outputs in the cycle after the write. The run bit falls only because of a write or a beat.
- R5: A beat on a running channel whose count is nonzero adds 2 (16-bit width) or 1 (8-bit width) to the address and subtracts 1 from the count. A beat on a stopped channel, or on a channel whose count is zero, changes nothing.
- R6: The beat that takes the count from 1 to 0 sets the terminal-count flag (control/status bit 8) and clears the run bit on the same edge.
- R7: A memory error input sets bit 9 and an address error input sets bit 10, whether or not the channel is running. Both flags stay set until software clears them.
- R8: Writing 1 to bit 8, 9 or 10 clears that flag, and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, it ends up set.
- R9: `irq` is 1 while at least one channel has interrupt enable set and has at least one of its three flags set.
- R10: Read data appears on `cpu_rdata` in the cycle after `cpu_rd`. The count register returns the residual count.
- R11: A software write to the address or count register in the same cycle as a beat takes precedence for that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 8 | Byte address inside the bank |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Registered read data |
| beat_done | input | 8 | Per-channel beat-completed strobe |
| hw_mem_err | input | 8 | Per-channel memory error report |
| hw_addr_err | input | 8 | Per-channel address error report |
| ch_enable | output | 8 | Per-channel run bit |
| ch_dir_wr | output | 8 | Per-channel direction, 1 = memory write |
| ch_wide | output | 8 | Per-channel 16-bit width select |
| ch_slow | output | 8 | Per-channel 120 ns access time select |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situations to reach are the same-edge collisions. The first is a flag being raised while software writes 1 to clear it. The second is a beat arriving while software rewrites the count or address register. The bench reaches both with a single-cycle driver task. That task places the write strobe, the beat strobe and the error strobes on the same clock edge. The terminal-beat case is reached by loading a count of 2 and issuing exactly two beats. A count of zero on a running channel is exercised separately, to show that its beats are discarded.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;
    localparam int NSEL      = 4;
    localparam int SEL_W     = 3;
    localparam int STRIDE_LG = 5;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_DIR_BIT = 1;
    localparam int FLG_TC_BIT  = 8;
    localparam int FLG_MEM_BIT = 9;
    localparam int FLG_ADR_BIT = 10;

    typedef enum logic [1:0] {
        SEL_SETUP = 2'd0,
        SEL_CTL   = 2'd1,
        SEL_ADDR  = 2'd2,
        SEL_CNT   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    typedef struct packed {
        logic slow;
        logic wide;
        logic ien;
    } setup_t;
endpackage

// File: rtl/dmarf_decode.sv
module dmarf_decode
    import dmarf_pkg::*;
#(
    parameter int NCH = 8,
    parameter int RAW = 8
) (
    input  logic                      cpu_wr,
    input  logic [RAW-1:0]            cpu_addr,
    output logic [NCH-1:0][NSEL-1:0]  wr_hit
);
    localparam int CHW = RAW - STRIDE_LG;

    logic [CHW-1:0]   ch_idx;
    logic [SEL_W-1:0] sel_idx;

    assign ch_idx  = cpu_addr[RAW-1:STRIDE_LG];
    assign sel_idx = cpu_addr[STRIDE_LG-1:2];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        for (genvar s = 0; s < NSEL; s++) begin : g_sel
            assign wr_hit[c][s] = cpu_wr && (ch_idx == CHW'(c)) && (sel_idx == SEL_W'(s));
        end
    end
endmodule

// File: rtl/dmarf_rdmux.sv
module dmarf_rdmux
    import dmarf_pkg::*;
#(
    parameter int NCH = 8,
    parameter int RAW = 8,
    parameter int DW  = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cpu_rd,
    input  logic [RAW-1:0]                    cpu_addr,
    input  logic [NCH-1:0][NSEL-1:0][DW-1:0]  words,
    output logic [DW-1:0]                     cpu_rdata
);
    localparam int CHW = RAW - STRIDE_LG;

    logic [CHW-1:0]   ch_idx;
    logic [SEL_W-1:0] sel_idx;
    logic [DW-1:0]    pick;

    assign ch_idx  = cpu_addr[RAW-1:STRIDE_LG];
    assign sel_idx = cpu_addr[STRIDE_LG-1:2];

    always_comb begin
        pick = '0;
        if (sel_idx < SEL_W'(NSEL))
            pick = words[ch_idx][sel_idx[1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cpu_rdata <= '0;
        else if (cpu_rd)
            cpu_rdata <= pick;
    end
endmodule

// File: rtl/dmarf_chan.sv
module dmarf_chan
    import dmarf_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSEL-1:0] wr_hit,
    input  logic [DW-1:0]   wdata,
    input  logic            beat,
    input  logic            mem_err_in,
    input  logic            addr_err_in,
    output setup_t          setup_q,
    output logic            run,
    output logic            dir_wr,
    output logic            tc_flag,
    output logic            mem_flag,
    output logic            adr_flag,
    output logic [AW-1:0]   addr_q,
    output logic [CW-1:0]   cnt_q
);
    ch_state_e state_q, state_d;
    logic      wr_setup, wr_ctl, wr_addr, wr_cnt;
    logic      beat_take, terminal;

    assign wr_setup  = wr_hit[SEL_SETUP];
    assign wr_ctl    = wr_hit[SEL_CTL];
    assign wr_addr   = wr_hit[SEL_ADDR];
    assign wr_cnt    = wr_hit[SEL_CNT];
    assign beat_take = beat && (state_q == CH_RUN) && (cnt_q != '0);
    assign terminal  = beat_take && !wr_cnt && (cnt_q == CW'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (wr_ctl && wdata[CTL_EN_BIT]) state_d = CH_RUN;
            CH_RUN: begin
                if (terminal)                          state_d = CH_IDLE;
                else if (wr_ctl && !wdata[CTL_EN_BIT]) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        run = (state_q == CH_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setup_q  <= '0;
            dir_wr   <= 1'b0;
            tc_flag  <= 1'b0;
            mem_flag <= 1'b0;
            adr_flag <= 1'b0;
            addr_q   <= '0;
            cnt_q    <= '0;
        end else begin
            if (wr_setup) setup_q <= setup_t'(wdata[2:0]);
            if (wr_ctl)   dir_wr  <= wdata[CTL_DIR_BIT];
            tc_flag  <= terminal    | (tc_flag  & ~(wr_ctl & wdata[FLG_TC_BIT]));
            mem_flag <= mem_err_in  | (mem_flag & ~(wr_ctl & wdata[FLG_MEM_BIT]));
            adr_flag <= addr_err_in | (adr_flag & ~(wr_ctl & wdata[FLG_ADR_BIT]));
            if (wr_addr)        addr_q <= wdata[AW-1:0];
            else if (beat_take) addr_q <= addr_q + (setup_q.wide ? AW'(2) : AW'(1));
            if (wr_cnt)         cnt_q <= wdata[CW-1:0];
            else if (beat_take) cnt_q <= cnt_q - CW'(1);
        end
    end
endmodule

// File: rtl/dmarf_regbank.sv
module dmarf_regbank
    import dmarf_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 24,
    parameter int CW  = 16,
    parameter int DW  = 32,
    parameter int RAW = $clog2(NCH) + STRIDE_LG
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_wr,
    input  logic           cpu_rd,
    input  logic [RAW-1:0] cpu_addr,
    input  logic [DW-1:0]  cpu_wdata,
    output logic [DW-1:0]  cpu_rdata,
    input  logic [NCH-1:0] beat_done,
    input  logic [NCH-1:0] hw_mem_err,
    input  logic [NCH-1:0] hw_addr_err,
    output logic [NCH-1:0] ch_enable,
    output logic [NCH-1:0] ch_dir_wr,
    output logic [NCH-1:0] ch_wide,
    output logic [NCH-1:0] ch_slow,
    output logic           irq
);
    logic [NCH-1:0][NSEL-1:0]          wr_hit;
    logic [NCH-1:0][NSEL-1:0][DW-1:0]  words;
    logic [NCH-1:0][AW-1:0]            addr_v;
    logic [NCH-1:0][CW-1:0]            cnt_v;
    logic [NCH-1:0]                    flag_tc, flag_me, flag_ae, ien_v;
    setup_t                            setup_v [NCH];

    dmarf_decode #(.NCH(NCH), .RAW(RAW)) u_decode (
        .cpu_wr   (cpu_wr),
        .cpu_addr (cpu_addr),
        .wr_hit   (wr_hit)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dmarf_chan #(.AW(AW), .CW(CW), .DW(DW)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_hit      (wr_hit[c]),
            .wdata       (cpu_wdata),
            .beat        (beat_done[c]),
            .mem_err_in  (hw_mem_err[c]),
            .addr_err_in (hw_addr_err[c]),
            .setup_q     (setup_v[c]),
            .run         (ch_enable[c]),
            .dir_wr      (ch_dir_wr[c]),
            .tc_flag     (flag_tc[c]),
            .mem_flag    (flag_me[c]),
            .adr_flag    (flag_ae[c]),
            .addr_q      (addr_v[c]),
            .cnt_q       (cnt_v[c])
        );

        assign ch_wide[c] = setup_v[c].wide;
        assign ch_slow[c] = setup_v[c].slow;
        assign ien_v[c]   = setup_v[c].ien;

        always_comb begin
            words[c]                       = '0;
            words[c][SEL_SETUP][2:0]       = setup_v[c];
            words[c][SEL_CTL][CTL_EN_BIT]  = ch_enable[c];
            words[c][SEL_CTL][CTL_DIR_BIT] = ch_dir_wr[c];
            words[c][SEL_CTL][FLG_TC_BIT]  = flag_tc[c];
            words[c][SEL_CTL][FLG_MEM_BIT] = flag_me[c];
            words[c][SEL_CTL][FLG_ADR_BIT] = flag_ae[c];
            words[c][SEL_ADDR][AW-1:0]     = addr_v[c];
            words[c][SEL_CNT][CW-1:0]      = cnt_v[c];
        end
    end

    assign irq = |(ien_v & (flag_tc | flag_me | flag_ae));

    dmarf_rdmux #(.NCH(NCH), .RAW(RAW), .DW(DW)) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_rd    (cpu_rd),
        .cpu_addr  (cpu_addr),
        .words     (words),
        .cpu_rdata (cpu_rdata)
    );
endmodule

// File: rtl/dmarf_regbank_chk.sv
module dmarf_regbank_chk #(
    parameter int NCH = 8,
    parameter int AW  = 24,
    parameter int CW  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cpu_wr,
    input logic [NCH-1:0]         beat_done,
    input logic [NCH-1:0]         hw_mem_err,
    input logic [NCH-1:0]         hw_addr_err,
    input logic [NCH-1:0]         ch_enable,
    input logic [NCH-1:0]         ch_wide,
    input logic                   irq,
    input logic [NCH-1:0][AW-1:0] addr_v,
    input logic [NCH-1:0][CW-1:0] cnt_v,
    input logic [NCH-1:0]         flag_tc,
    input logic [NCH-1:0]         flag_me,
    input logic [NCH-1:0]         flag_ae,
    input logic [NCH-1:0]         ien_v
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (ch_enable == '0 && irq == 1'b0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_run_fall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_enable[c]) |-> ($past(cpu_wr) || $past(beat_done[c])));

        assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (beat_done[c] && ch_enable[c] && cnt_v[c] != '0 && !cpu_wr)
            |=> (addr_v[c] == $past(addr_v[c]) + ($past(ch_wide[c]) ? AW'(2) : AW'(1))));

        assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (beat_done[c] && !ch_enable[c] && !cpu_wr) |=> $stable(cnt_v[c]));

        assert_terminal_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (beat_done[c] && ch_enable[c] && cnt_v[c] == CW'(1) && !cpu_wr)
            |=> (!ch_enable[c] && flag_tc[c]));

        assert_mem_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
            hw_mem_err[c] |=> flag_me[c]);

        assert_addr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
            hw_addr_err[c] |=> flag_ae[c]);

        assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_ae[c] && !cpu_wr) |=> flag_ae[c]);

        assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_mem_err[c] && ien_v[c] && !cpu_wr) |=> irq);
    end
endmodule

bind dmarf_regbank dmarf_regbank_chk #(.NCH(NCH), .AW(AW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_wr      (cpu_wr),
    .beat_done   (beat_done),
    .hw_mem_err  (hw_mem_err),
    .hw_addr_err (hw_addr_err),
    .ch_enable   (ch_enable),
    .ch_wide     (ch_wide),
    .irq         (irq),
    .addr_v      (addr_v),
    .cnt_v       (cnt_v),
    .flag_tc     (flag_tc),
    .flag_me     (flag_me),
    .flag_ae     (flag_ae),
    .ien_v       (ien_v)
);

// File: tb/dmarf_regbank_bench.sv
`timescale 1ns/1ps
module dmarf_regbank_bench;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic [7:0]  beat_done = '0;
    logic [7:0]  hw_mem_err = '0;
    logic [7:0]  hw_addr_err = '0;
    logic [7:0]  ch_enable, ch_dir_wr, ch_wide, ch_slow;
    logic        irq;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    dmarf_regbank u_dmarf_regbank (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .beat_done(beat_done), .hw_mem_err(hw_mem_err), .hw_addr_err(hw_addr_err),
        .ch_enable(ch_enable), .ch_dir_wr(ch_dir_wr), .ch_wide(ch_wide),
        .ch_slow(ch_slow), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ra(input int ch, input int sel);
        return 8'(ch * 32 + sel * 4);
    endfunction

    task automatic cycle(input logic wr, input logic [7:0] a, input logic [31:0] d,
                         input logic [7:0] bt, input logic [7:0] me, input logic [7:0] ae);
        cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
        beat_done = bt; hw_mem_err = me; hw_addr_err = ae;
        @(posedge clk);
        @(negedge clk);
        cpu_wr = 1'b0; beat_done = '0; hw_mem_err = '0; hw_addr_err = '0;
    endtask

    task automatic wr(input int ch, input int sel, input logic [31:0] d);
        cycle(1'b1, ra(ch, sel), d, '0, '0, '0);
    endtask

    task automatic beat(input int ch);
        cycle(1'b0, '0, '0, 8'(1 << ch), '0, '0);
    endtask

    task automatic rd(input int ch, input int sel, output logic [31:0] d);
        cpu_rd = 1'b1; cpu_addr = ra(ch, sel);
        @(posedge clk);
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 enables", 32'(ch_enable), 0);
        chk("R1 irq", 32'(irq), 0);
        rd(0, 1, d); chk("R1 ctl ch0", d, 0);
        rd(7, 3, d); chk("R1 count ch7", d, 0);
    endtask

    task automatic t_decode();
        logic [31:0] d;
        wr(3, 2, 32'h123456);
        wr(5, 2, 32'h00ABCD);
        rd(3, 2, d); chk("R2 ch3 addr", d, 32'h123456);
        rd(5, 2, d); chk("R2 ch5 addr", d, 32'h00ABCD);
        rd(4, 2, d); chk("R2 ch4 untouched", d, 0);
        wr(3, 5, 32'hFFFFFFFF);
        rd(3, 5, d); chk("R2 unmapped reads 0", d, 0);
        rd(3, 2, d); chk("R2 unmapped write ignored", d, 32'h123456);
        rd(3, 0, d); chk("R2 unmapped write no setup", d, 0);
    endtask

    task automatic t_setup();
        logic [31:0] d;
        wr(2, 0, 32'h6);
        chk("R3 wide", 32'(ch_wide[2]), 1);
        chk("R3 slow", 32'(ch_slow[2]), 1);
        rd(2, 0, d); chk("R3 readback", d, 6);
        wr(2, 0, 32'h1);
        chk("R3 narrow", 32'(ch_wide[2]), 0);
        chk("R3 fast", 32'(ch_slow[2]), 0);
    endtask

    task automatic t_run();
        logic [31:0] d;
        wr(1, 0, 32'h2);
        wr(1, 2, 32'h1000);
        wr(1, 3, 32'd5);
        wr(1, 1, 32'h3);
        chk("R4 enable", 32'(ch_enable[1]), 1);
        chk("R4 dir write", 32'(ch_dir_wr[1]), 1);
        beat(1); beat(1);
        rd(1, 2, d); chk("R5 addr wide step", d, 32'h1004);
        rd(1, 3, d); chk("R10 residual", d, 3);
        wr(1, 1, 32'h2);
        chk("R4 disable", 32'(ch_enable[1]), 0);
        chk("R4 dir kept", 32'(ch_dir_wr[1]), 1);
        beat(1);
        rd(1, 3, d); chk("R5 stopped beat ignored", d, 3);
        wr(7, 1, 32'h1);
        beat(7);
        rd(7, 2, d); chk("R5 zero count beat ignored", d, 0);
        chk("R5 zero count stays running", 32'(ch_enable[7]), 1);
        wr(7, 1, 32'h0);
    endtask

    task automatic t_terminal();
        logic [31:0] d;
        wr(1, 0, 32'h0);
        wr(1, 2, 32'h2000);
        wr(1, 3, 32'd2);
        wr(1, 1, 32'h1);
        beat(1);
        chk("R6 still running", 32'(ch_enable[1]), 1);
        beat(1);
        chk("R6 run cleared", 32'(ch_enable[1]), 0);
        rd(1, 1, d); chk("R6 tc flag", d, 32'h100);
        rd(1, 2, d); chk("R5 addr narrow step", d, 32'h2002);
        rd(1, 3, d); chk("R6 count zero", d, 0);
        chk("R9 no irq without enable", 32'(irq), 0);
    endtask

    task automatic t_errors();
        logic [31:0] d;
        cycle(1'b0, '0, '0, '0, 8'h40, '0);
        repeat (3) @(negedge clk);
        rd(6, 1, d); chk("R7 mem flag sticky", d, 32'h200);
        cycle(1'b0, '0, '0, '0, '0, 8'h40);
        rd(6, 1, d); chk("R7 addr flag", d, 32'h600);
        wr(6, 1, 32'h200);
        rd(6, 1, d); chk("R8 w1c mem", d, 32'h400);
        wr(6, 1, 32'h0);
        rd(6, 1, d); chk("R8 write 0 keeps", d, 32'h400);
        cycle(1'b1, ra(6, 1), 32'h400, '0, '0, 8'h40);
        rd(6, 1, d); chk("R8 set wins over clear", d, 32'h400);
        wr(6, 1, 32'h400);
        rd(6, 1, d); chk("R8 cleared", d, 0);
    endtask

    task automatic t_irq();
        wr(1, 0, 32'h1);
        chk("R9 irq from tc", 32'(irq), 1);
        wr(1, 1, 32'h100);
        chk("R9 irq cleared", 32'(irq), 0);
        wr(6, 0, 32'h1);
        cycle(1'b0, '0, '0, '0, 8'h40, '0);
        chk("R9 irq from mem err", 32'(irq), 1);
        wr(6, 1, 32'h200);
        chk("R9 irq off", 32'(irq), 0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        wr(0, 0, 32'h0);
        wr(0, 2, 32'h10);
        wr(0, 3, 32'd4);
        wr(0, 1, 32'h1);
        cycle(1'b1, ra(0, 3), 32'd9, 8'h01, '0, '0);
        rd(0, 3, d); chk("R11 count write wins", d, 9);
        rd(0, 2, d); chk("R11 addr advanced", d, 32'h11);
        cycle(1'b1, ra(0, 2), 32'h40, 8'h01, '0, '0);
        rd(0, 2, d); chk("R11 addr write wins", d, 32'h40);
        rd(0, 3, d); chk("R11 count decremented", d, 8);
        wr(0, 1, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_setup();
        t_run();
        t_terminal();
        t_errors();
        t_irq();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule